// File: doc/BRIEF.md
# Single-Precision Float to S15.16 Fixed-Point Converter

This block turns a 32-bit binary floating-point word into a signed 32-bit fixed-point number with 16 fraction bits. The result is the input value times 65536, rounded to the nearest integer, with exact halves going to the even neighbour. The word is split into its sign, exponent and fraction fields, and the hidden leading one is restored. The significand is then moved so that its units bit lands on output bit 16. When the move is to the right, a round bit and a sticky bit are formed from the bits that drop off, and they decide whether the result is incremented.

Zero and subnormal inputs give 0. Magnitudes of 2^15 or more, infinities included, clamp to the largest or smallest output code, and a NaN gives 0. The converter sits in a stream with one register stage. An input word is taken when `in_valid` and `in_ready` are both high, and its result appears on the next cycle with `out_valid` set. While `out_valid` is high and `out_ready` is low, the output word stays unchanged. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-pressure therefore passes straight through, with no extra buffering.

Top module: `flt_to_sfix`

## Requirements
- R1: When the unbiased exponent is 7 or more and below 15, the output equals the significand (fraction bits with a leading one at bit 23) shifted left by (exponent field − 134). No bits are lost and no rounding is applied.
- R2: An exponent field of 0 (zero, negative zero and subnormals) gives an output of 0.
- R3: On a right shift, if the dropped part is more than half an output LSB, the truncated magnitude is incremented by one.
- R4: On a right shift, if the dropped part is exactly half an output LSB, the magnitude rounds to the even neighbour.
- R5: On a right shift, if the dropped part is less than half an output LSB, the truncated magnitude is kept unchanged.
- R6: A set sign bit (bit 31) gives the two's-complement negation of the rounded magnitude.
- R7: An exponent field of 142 or more that is not a NaN gives 0x7FFFFFFF for a positive input and 0x80000000 for a negative input.
- R8: Exponent field 255 with a nonzero fraction (NaN) gives 0.
- R9: The right-shift distance is limited to 31. Inputs smaller in magnitude than 2^-17 give 0, and the limit never produces a nonzero result.
- R10: A result appears one cycle after its input is accepted. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R11: A synchronous active-high `rst` clears `out_valid` on the next clock edge.
- R12: The two rounding implementations selected by `ROUND_IMPL` (0: conditional increment, 1: increment then clear the LSB on a tie) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Converter can take a word this cycle |
| in_data | input | 32 | Single-precision input word |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | OUT_W | S15.16 result |

## Verification
Every exponent code is swept with a fixed set of fraction patterns in both signs. This separates the zero/subnormal, shift-left, shift-right, saturation, infinity and NaN regions of the input space. For several exponents that drop between 6 and 9 bits, all 256 values of the low fraction byte are swept. These cases tell below-half, exact-tie and above-half apart, and split ties on odd and even truncated values. Directed words cover the 0.1-step values between 1 and 4, ties that sit just below the smallest output LSB, and the words just inside and just outside the saturation limit. All of this runs under random stalls on both sides of the stream, with a second instance using the other rounding implementation compared output for output.

// File: rtl/flt_fix_pkg.sv
package flt_fix_pkg;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;
  localparam int FP_W     = 1 + FP_EXP_W + FP_MAN_W;
  localparam int SIG_W    = FP_MAN_W + 1;
  localparam int FP_BIAS  = (1 << (FP_EXP_W - 1)) - 1;

  typedef struct packed {
    logic                sign;
    logic [FP_EXP_W-1:0] expo;
    logic [FP_MAN_W-1:0] frac;
  } fp_word_t;
endpackage

// File: rtl/fx_unpack.sv
module fx_unpack
  import flt_fix_pkg::*;
#(
  parameter int OUT_W  = 32,
  parameter int FRAC_W = 16,
  localparam int SH_W  = $clog2(OUT_W)
) (
  input  logic [FP_W-1:0]  word,
  output logic             sign,
  output logic [SIG_W-1:0] sig,
  output logic             go_left,
  output logic [SH_W-1:0]  shamt,
  output logic             is_nan,
  output logic             is_big
);
  localparam int ALIGN   = FP_MAN_W - FRAC_W;
  localparam int SAT_EXP = FP_BIAS + OUT_W - FRAC_W - 1;
  localparam int MAX_SH  = OUT_W - 1;

  fp_word_t f;
  int       sc;

  always_comb begin
    f      = fp_word_t'(word);
    sign   = f.sign;
    sig    = (f.expo != '0) ? {1'b1, f.frac} : '0;
    is_nan = (f.expo == '1) && (f.frac != '0);
    is_big = (int'(f.expo) >= SAT_EXP) && !is_nan;
    sc     = int'(f.expo) - FP_BIAS - ALIGN;
    if (sc > MAX_SH)  sc = MAX_SH;
    if (sc < -MAX_SH) sc = -MAX_SH;
    go_left = (sc >= 0);
    shamt   = go_left ? SH_W'(sc) : SH_W'(-sc);
  end

  always_comb begin
    if (f.expo == '0)
      assert_zero_sig_R2: assert (sig == '0) else $error("R2: significand not cleared");
  end
endmodule

// File: rtl/fx_shift_round.sv
module fx_shift_round
  import flt_fix_pkg::*;
#(
  parameter int OUT_W      = 32,
  parameter int ROUND_IMPL = 0,
  localparam int SH_W      = $clog2(OUT_W)
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             go_left,
  input  logic [SH_W-1:0]  shamt,
  output logic [OUT_W-1:0] mag
);
  localparam int EXT_W = SIG_W + OUT_W;

  logic [EXT_W-1:0] ext;
  logic [OUT_W-1:0] trunc;
  logic [OUT_W-1:0] left;
  logic [OUT_W-1:0] rounded;
  logic             rbit;
  logic             sticky;

  always_comb begin
    ext    = {sig, {OUT_W{1'b0}}} >> shamt;
    trunc  = OUT_W'(ext[EXT_W-1:OUT_W]);
    rbit   = ext[OUT_W-1];
    sticky = |ext[OUT_W-2:0];
    left   = OUT_W'(sig) << shamt;
  end

  generate
    if (ROUND_IMPL == 0) begin : g_cond_inc
      always_comb rounded = trunc + OUT_W'(rbit & (sticky | trunc[0]));
    end else begin : g_inc_clear
      logic [OUT_W-1:0] bumped;
      always_comb begin
        bumped  = trunc + OUT_W'(rbit);
        rounded = (rbit && !sticky) ? (bumped & ~OUT_W'(1)) : bumped;
      end
    end
  endgenerate

  assign mag = go_left ? left : rounded;

  always_comb begin
    if (!go_left && !rbit)
      assert_below_half_keep_R5: assert (rounded == trunc) else $error("R5: rounded below half");
    if (!go_left && rbit && !sticky)
      assert_tie_even_R4: assert (!rounded[0]) else $error("R4: tie not even");
    if (!go_left && rbit && sticky)
      assert_above_half_up_R3: assert (rounded == trunc + OUT_W'(1)) else $error("R3: no round up");
    if (go_left && int'(shamt) <= OUT_W - SIG_W)
      assert_left_lossless_R1: assert ((left >> shamt) == OUT_W'(sig)) else $error("R1: bits lost");
  end
endmodule

// File: rtl/fx_sign_sat.sv
module fx_sign_sat #(
  parameter int OUT_W = 32
) (
  input  logic             sign,
  input  logic             is_nan,
  input  logic             is_big,
  input  logic [OUT_W-1:0] mag,
  output logic [OUT_W-1:0] res
);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (is_nan)      res = '0;
    else if (is_big) res = sign ? NEG_MIN : POS_MAX;
    else if (sign)   res = -mag;
    else             res = mag;
  end

  always_comb begin
    if (is_big && !is_nan)
      assert_sat_sign_R7: assert (res[OUT_W-1] == sign) else $error("R7: saturation sign");
    if (!is_big && !is_nan && mag != '0)
      assert_neg_sign_R6: assert (res[OUT_W-1] == sign) else $error("R6: result sign");
    if (is_nan)
      assert_nan_zero_R8: assert (res == '0) else $error("R8: NaN not zero");
  end
endmodule

// File: rtl/flt_to_sfix.sv
module flt_to_sfix
  import flt_fix_pkg::*;
#(
  parameter int OUT_W      = 32,
  parameter int FRAC_W     = 16,
  parameter int ROUND_IMPL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int SH_W = $clog2(OUT_W);

  logic             sign, go_left, is_nan, is_big;
  logic [SIG_W-1:0] sig;
  logic [SH_W-1:0]  shamt;
  logic [OUT_W-1:0] mag, res;

  fx_unpack #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_unpack (
    .word(in_data), .sign(sign), .sig(sig), .go_left(go_left),
    .shamt(shamt), .is_nan(is_nan), .is_big(is_big)
  );

  fx_shift_round #(.OUT_W(OUT_W), .ROUND_IMPL(ROUND_IMPL)) u_round (
    .sig(sig), .go_left(go_left), .shamt(shamt), .mag(mag)
  );

  fx_sign_sat #(.OUT_W(OUT_W)) u_sat (
    .sign(sign), .is_nan(is_nan), .is_big(is_big), .mag(mag), .res(res)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
    if (!rst && in_valid && in_ready) out_data <= res;
  end

  assert_reset_clears_R11: assert property (@(posedge clk) rst |=> !out_valid)
    else $error("R11: out_valid after reset");

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("R10: output moved under stall");

  assert_accept_latency_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid)
    else $error("R10: accepted word not presented");
endmodule

// File: tb/flt_to_sfix_test.sv
module flt_to_sfix_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, in_ready_alt, out_valid_alt;
  logic [31:0] out_data, out_data_alt;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  flt_to_sfix #(.ROUND_IMPL(0)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  flt_to_sfix #(.ROUND_IMPL(1)) uut_alt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready_alt), .in_data(in_data),
    .out_valid(out_valid_alt), .out_ready(out_ready), .out_data(out_data_alt));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: value * 65536 from integer significand and remainder comparison.
  function automatic logic [31:0] ref_conv(input logic [31:0] w);
    longint m, q, rem, half;
    int e, k, n;
    e = int'(w[30:23]);
    if (e == 255 && w[22:0] != 0) return 32'h0;
    if (e == 0) return 32'h0;
    if (e >= 142) return w[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    m = longint'({1'b1, w[22:0]});
    k = e - 134;
    if (k >= 0) q = m << k;
    else begin
      n = -k;
      if (n >= 40) q = 0;
      else begin
        q = m >> n;
        rem = m - (q << n);
        half = longint'(1) << (n - 1);
        if (rem > half || (rem == half && q[0])) q = q + 1;
      end
    end
    return w[31] ? -q[31:0] : q[31:0];
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    longint m, rem, half;
    int e, n;
    string t;
    e = int'(w[30:23]);
    m = longint'({1'b1, w[22:0]});
    if (e == 255 && w[22:0] != 0) t = "R8";
    else if (e == 0) t = "R2";
    else if (e >= 142) t = "R7";
    else if (e >= 134) t = "R1";
    else begin
      n = 134 - e;
      if (n >= 25) t = "R9";
      else begin
        half = longint'(1) << (n - 1);
        rem  = m & ((longint'(1) << n) - 1);
        t = (rem > half) ? "R3" : (rem == half) ? "R4" : "R5";
      end
    end
    if (w[31] && e != 0 && !(e == 255 && w[22:0] != 0)) t = {t, " R6"};
    return t;
  endfunction

  logic [31:0] vecs[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [22:0] pats[8];
    int vi;
    bit pending, stall_prev;
    logic [31:0] stall_data, ev;
    string tg;

    pats = '{23'h0, 23'h7FFFFF, 23'h400000, 23'h000001, 23'h555555, 23'h2AAAAA, 23'h400040, 23'h000080};
    for (int e = 0; e < 256; e++)
      for (int p = 0; p < 8; p++)
        for (int s = 0; s < 2; s++)
          vecs.push_back({s[0], e[7:0], pats[p]});
    foreach (pats[p]) begin end
    for (int ei = 0; ei < 4; ei++)
      for (int lb = 0; lb < 256; lb++)
        for (int s = 0; s < 2; s++) begin
          int ex;
          ex = (ei == 0) ? 125 : (ei == 1) ? 126 : (ei == 2) ? 127 : 128;
          vecs.push_back({s[0], ex[7:0], 7'h2B, 8'h5A, lb[7:0]});
        end
    vecs.push_back(32'h3F8CCCCD); vecs.push_back(32'h3F99999A); vecs.push_back(32'h3FA66666);
    vecs.push_back(32'h3FD9999A); vecs.push_back(32'h40066666); vecs.push_back(32'h400CCCCD);
    vecs.push_back(32'h40133333); vecs.push_back(32'h4019999A); vecs.push_back(32'h402CCCCD);
    vecs.push_back(32'h40466666); vecs.push_back(32'h40533333); vecs.push_back(32'h4079999A);
    vecs.push_back(32'h47000000); vecs.push_back(32'hC7000000); vecs.push_back(32'h46FFFFFF);
    vecs.push_back(32'hC6FFFFFF); vecs.push_back(32'h7F800000); vecs.push_back(32'hFF800000);
    vecs.push_back(32'h7FC00000); vecs.push_back(32'h80000000); vecs.push_back(32'h37800000);
    vecs.push_back(32'h37000000); vecs.push_back(32'h37400000); vecs.push_back(32'h37C00000);
    vecs.push_back(32'hB7C00000); vecs.push_back(32'h00000001);

    // Directed values with hand-computed results (R1, R4, R7, R9).
    chk(ref_conv(32'h46FFFFFF) == 32'h7FFFFF80, "R1 ref", ref_conv(32'h46FFFFFF), 32'h7FFFFF80);
    chk(ref_conv(32'h37C00000) == 32'h2, "R4 ref", ref_conv(32'h37C00000), 32'h2);
    chk(ref_conv(32'hC7000000) == 32'h80000000, "R7 ref", ref_conv(32'hC7000000), 32'h80000000);
    chk(ref_conv(32'h37000000) == 32'h0, "R9 ref", ref_conv(32'h37000000), 32'h0);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R11 reset out_valid", 32'(out_valid), 32'h0);
    chk(in_ready == 1'b1, "R10 ready when empty", 32'(in_ready), 32'h1);

    vi = 0; pending = 0; stall_prev = 0; stall_data = '0;
    while (vi < vecs.size() || exp_q.size() > 0 || pending) begin
      @(negedge clk);
      if (stall_prev)
        chk(out_valid && out_data == stall_data, "R10 stall hold", out_data, stall_data);
      out_ready = ($urandom % 4) != 0;
      if (!pending && vi < vecs.size() && ($urandom % 6) != 0) pending = 1;
      in_valid = pending;
      in_data  = pending ? vecs[vi] : 32'h0;
      #1;
      chk(in_ready == (!out_valid || out_ready), "R10 ready rule", 32'(in_ready), 32'(!out_valid || out_ready));
      if (out_valid)
        chk(out_valid_alt && out_data_alt == out_data, "R12 impl match", out_data_alt, out_data);
      if (out_valid && out_ready) begin
        ev = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(out_data == ev, tg, out_data, ev);
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_conv(vecs[vi]));
        tag_q.push_back(tag_of(vecs[vi]));
        vi++;
        pending = 0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R11 mid-run reset", 32'(out_valid), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule